// File: doc/BRIEF.md
# Snapshot-Read Timer Counter Unit

This block is one counting unit of a system timer: a free-running 52-bit up-counter that software can preset and read without tearing. The counter is never read directly. Software raises an update strobe. One cycle later the block copies the live count into a read-back register and raises a valid flag. Software polls that flag before it reads the high and low words. A load strobe copies a 52-bit preset, given as a 20-bit high word and a 32-bit low word, into the counter.

Counting is gated by a work enable and by one stall input per CPU core. Each stall input has its own mask bit, and a stall only freezes the counter when its mask bit is set. The enable and mask bits are held in the unit and written through a one-cycle configuration strobe. Their reset values depend on the unit index. Unit 0 comes out of reset counting and ignores stalls. Any other unit comes out of reset idle, with every stall mask bit set.

Top module: `tmr_snap_unit`

## Requirements
- R1: The count is HI_W+LO_W bits (20+32 = 52 by default). `load_hi`/`value_hi` carry count bits 51:32 and `load_lo`/`value_lo` carry bits 31:0.
- R2: A cycle with `load_stb` high sets the count to {`load_hi`,`load_lo`} at that clock edge.
- R3: When `update_stb` is sampled at edge E, the read-back value becomes the count held just after E, and it appears at edge E+1.
- R4: The clock edge that samples `update_stb` clears `value_valid`.
- R5: `value_valid` rises at the edge after the update strobe, in the same cycle the new snapshot appears, and it stays high until the next update strobe.
- R6: When `load_stb` and `update_stb` are high in the same cycle, the load wins and the snapshot holds the loaded value.
- R7: While running, the count rises by exactly one per cycle. It wraps from 2^52-1 to 0 and gives no indication of the wrap.
- R8: While the work enable is 0, the count holds. A `cfg_wr` pulse stores `cfg_work_en` and `cfg_stall_mask`, and they take effect from the next cycle.
- R9: A high `core_stall[i]` freezes the count only while mask bit i is set. With mask bit i clear, that stall input is ignored.
- R10: After reset the read-back value is 0 and `value_valid` is 0. With UNIT_ID 0 the work enable is 1 and the stall mask is all zeros. With any other UNIT_ID the work enable is 0 and the stall mask is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_hi | input | HI_W | Preset, high word |
| load_lo | input | LO_W | Preset, low word |
| load_stb | input | 1 | One-cycle load request |
| update_stb | input | 1 | One-cycle snapshot request |
| cfg_wr | input | 1 | Stores enable and mask inputs |
| cfg_work_en | input | 1 | Work enable value to store |
| cfg_stall_mask | input | N_CORES | Per-core stall mask value to store |
| core_stall | input | N_CORES | Per-core stall indication |
| value_hi | output | HI_W | Snapshot, high word |
| value_lo | output | LO_W | Snapshot, low word |
| value_valid | output | 1 | Snapshot valid flag |

## Verification
The bench builds two units at the default 20/32-bit split with two cores. One unit has UNIT_ID 0 and the other UNIT_ID 1, so both sets of reset enables are seen on the same stimulus. Because the split is at full width, loads near 2^52-1 bring the wrap and carries across the word boundary within a few cycles. A scoreboard compares every snapshot against a requirement-level model of count, enable and mask.

// File: rtl/tmr_pkg.sv
// Package: shared defaults and reset-value helpers for the timer counter unit.
// Assumes: the unit index only selects reset values and no behaviour.
package tmr_pkg;
    localparam int DEF_HI_W    = 20;
    localparam int DEF_LO_W    = 32;
    localparam int DEF_N_CORES = 2;

    // Reset value of the work enable for a given unit index.
    function automatic logic rst_work_en(input int unit_id);
        return (unit_id == 0);
    endfunction

    // Reset value of each stall mask bit for a given unit index.
    function automatic logic rst_mask_bit(input int unit_id);
        return (unit_id != 0);
    endfunction
endpackage

// File: rtl/tmr_run_gate.sv
// Module: holds the work enable and the per-core stall mask, and produces the
// count-permission signal.
// Assumes: cfg_wr is a one-cycle strobe. Stored values apply from the next cycle.
module tmr_run_gate
    import tmr_pkg::*;
#(
    parameter int N_CORES = DEF_N_CORES,
    parameter int UNIT_ID = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_work_en,
    input  logic [N_CORES-1:0] cfg_stall_mask,
    input  logic [N_CORES-1:0] core_stall,
    output logic [N_CORES-1:0] stall_mask_q,
    output logic               run
);
    logic               work_q;
    logic [N_CORES-1:0] stall_hit;

    // Configuration storage, with reset values chosen by the unit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q       <= rst_work_en(UNIT_ID);
            stall_mask_q <= {N_CORES{rst_mask_bit(UNIT_ID)}};
        end else if (cfg_wr) begin
            work_q       <= cfg_work_en;
            stall_mask_q <= cfg_stall_mask;
        end
    end

    // One qualifier per core: the stall counts only when its mask bit is set.
    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        assign stall_hit[c] = core_stall[c] & stall_mask_q[c];
    end

    // Count permission.
    always_comb run = work_q & ~(|stall_hit);
endmodule

// File: rtl/tmr_count_core.sv
// Module: the wide up-counter, with a preset load that takes priority over
// counting.
// Assumes: the wrap at the top of the range is silent.
module tmr_count_core #(
    parameter int CNT_W = 52
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic [CNT_W-1:0] count
);
    // Counter register: load first, then increment while permitted.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= load_val;
        else if (run)  count <= count + 1'b1;
    end

    // R2: a load lands at the next edge.
    a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));
    // R7: a running cycle adds exactly one, modulo the width.
    a_r7_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && run) |=> (count == $past(count) + 1'b1));
    // R8: no load and no permission means the count holds.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable(count));
endmodule

// File: rtl/tmr_snapshot.sv
// Module: captures the count one cycle after an update request and manages
// the valid flag.
// Assumes: update requests are one-cycle strobes. A request clears the flag
// at once, and the flag returns with the capture.
module tmr_snapshot #(
    parameter int CNT_W = 52
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             update,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] snap,
    output logic             valid
);
    logic pend;

    // Request pipeline: remember that a capture is due on the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= update;
    end

    // Capture register and valid flag. A new request clears the flag first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap  <= '0;
            valid <= 1'b0;
        end else begin
            if (pend) snap <= count;
            if (update)    valid <= 1'b0;
            else if (pend) valid <= 1'b1;
        end
    end

    // R4: a request drops the flag at the next edge.
    a_r4_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> !valid);
    // R5: a pending capture with no new request raises the flag.
    a_r5_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !update) |=> valid);
    // R3: the capture takes the count present in the cycle after the request.
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> (snap == $past(count)));
    // R5: with no request and no capture due, the flag holds.
    a_r5_valid_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !update) |=> $stable(valid));
endmodule

// File: rtl/tmr_snap_unit.sv
// Module: top of one timer counting unit. It joins the run gate, the counter
// and the snapshot logic, and splits the snapshot into high and low words.
// Assumes: all strobes are synchronous to clk and one cycle wide.
module tmr_snap_unit
    import tmr_pkg::*;
#(
    parameter int HI_W    = DEF_HI_W,
    parameter int LO_W    = DEF_LO_W,
    parameter int N_CORES = DEF_N_CORES,
    parameter int UNIT_ID = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HI_W-1:0]    load_hi,
    input  logic [LO_W-1:0]    load_lo,
    input  logic               load_stb,
    input  logic               update_stb,
    input  logic               cfg_wr,
    input  logic               cfg_work_en,
    input  logic [N_CORES-1:0] cfg_stall_mask,
    input  logic [N_CORES-1:0] core_stall,
    output logic [HI_W-1:0]    value_hi,
    output logic [LO_W-1:0]    value_lo,
    output logic               value_valid
);
    localparam int CNT_W = HI_W + LO_W;

    logic               run;
    logic [N_CORES-1:0] stall_mask_q;
    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   snap;

    tmr_run_gate #(.N_CORES(N_CORES), .UNIT_ID(UNIT_ID)) u_gate (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_work_en(cfg_work_en),
        .cfg_stall_mask(cfg_stall_mask), .core_stall(core_stall),
        .stall_mask_q(stall_mask_q), .run(run)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .load(load_stb),
        .load_val({load_hi, load_lo}), .run(run), .count(count)
    );

    tmr_snapshot #(.CNT_W(CNT_W)) u_snap (
        .clk(clk), .rst_n(rst_n), .update(update_stb), .count(count),
        .snap(snap), .valid(value_valid)
    );

    // Word split of the read-back value.
    always_comb begin
        value_hi = snap[CNT_W-1:LO_W];
        value_lo = snap[LO_W-1:0];
    end

    // R9: a masked stall with no load freezes the counter.
    a_r9_masked_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_stb && |(core_stall & stall_mask_q)) |=> $stable(count));
    // R6: load together with update gives the loaded value in the snapshot.
    a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && update_stb) |=> ##1 (snap == $past({load_hi, load_lo}, 2)));
endmodule

// File: tb/tmr_snap_unit_tb.sv
// Bench: a scoreboard for the timer counting unit. The driver pushes expected
// snapshots, computed by a requirement-level model, and the monitor pops and
// compares them each time value_valid rises.
module tmr_snap_unit_tb;
    localparam int HI_W = 20;
    localparam int LO_W = 32;
    localparam int NC   = 2;
    localparam int CW   = HI_W + LO_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [HI_W-1:0] load_hi = '0;
    logic [LO_W-1:0] load_lo = '0;
    logic load_stb = 1'b0, update_stb = 1'b0, cfg_wr = 1'b0, cfg_work_en = 1'b0;
    logic [NC-1:0] cfg_stall_mask = '0, core_stall = '0;
    logic [HI_W-1:0] value_hi, v1_hi;
    logic [LO_W-1:0] value_lo, v1_lo;
    logic value_valid, v1_valid;

    int n_chk = 0;
    int n_fail = 0;
    logic [CW-1:0] exp_q[$];
    logic [CW-1:0] m_cnt;
    logic m_work;
    logic [NC-1:0] m_mask;
    logic prev_valid = 1'b0;

    always #10 clk = ~clk;

    tmr_snap_unit #(.HI_W(HI_W), .LO_W(LO_W), .N_CORES(NC), .UNIT_ID(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_hi(load_hi), .load_lo(load_lo),
        .load_stb(load_stb), .update_stb(update_stb), .cfg_wr(cfg_wr),
        .cfg_work_en(cfg_work_en), .cfg_stall_mask(cfg_stall_mask),
        .core_stall(core_stall), .value_hi(value_hi), .value_lo(value_lo),
        .value_valid(value_valid)
    );

    tmr_snap_unit #(.HI_W(HI_W), .LO_W(LO_W), .N_CORES(NC), .UNIT_ID(1)) u_dut1 (
        .clk(clk), .rst_n(rst_n), .load_hi(load_hi), .load_lo(load_lo),
        .load_stb(load_stb), .update_stb(update_stb), .cfg_wr(cfg_wr),
        .cfg_work_en(cfg_work_en), .cfg_stall_mask(cfg_stall_mask),
        .core_stall(core_stall), .value_hi(v1_hi), .value_lo(v1_lo),
        .value_valid(v1_valid)
    );

    // Reference model of the unit-0 count, written from R2, R7, R8, R9, R10.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= '0; m_work <= 1'b1; m_mask <= '0;
        end else begin
            if (cfg_wr) begin m_work <= cfg_work_en; m_mask <= cfg_stall_mask; end
            if (load_stb) m_cnt <= {load_hi, load_lo};
            else if (m_work && ((core_stall & m_mask) == '0)) m_cnt <= m_cnt + 1'b1;
        end
    end

    task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected snapshot each time value_valid rises (R3, R5, R1).
    always @(negedge clk) begin
        if (rst_n) begin
            if (value_valid && !prev_valid) begin
                if (exp_q.size() == 0) check("R5 unexpected valid", 1, 0);
                else check("R3 snapshot", {value_hi, value_lo}, exp_q.pop_front());
            end
            prev_valid <= value_valid;
        end else prev_valid <= 1'b0;
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Driver: update strobe, optionally with a load. Pushes the expected value
    // and checks the flag timing of R4/R5.
    task automatic do_update(input string req, input logic with_load, input logic [CW-1:0] lv);
        @(negedge clk);
        update_stb = 1'b1;
        load_stb = with_load;
        {load_hi, load_lo} = lv;
        @(posedge clk);
        #1 exp_q.push_back(m_cnt);
        @(negedge clk);
        update_stb = 1'b0;
        load_stb = 1'b0;
        check({req, " R4 valid low after strobe"}, CW'(value_valid), 0);
        @(negedge clk);
        check({req, " R5 valid high next cycle"}, CW'(value_valid), 1);
    endtask

    task automatic do_load(input logic [CW-1:0] lv);
        @(negedge clk);
        load_stb = 1'b1;
        {load_hi, load_lo} = lv;
        @(negedge clk);
        load_stb = 1'b0;
    endtask

    task automatic do_cfg(input logic we, input logic [NC-1:0] mk);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_work_en = we; cfg_stall_mask = mk;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [CW-1:0] s1;
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state of the read-back path
        check("R10 reset value", {value_hi, value_lo}, 0);
        check("R10 reset valid", CW'(value_valid), 0);
        cycles(4);
        // R10: unit 0 counts and unit 1 stays idle after reset
        do_update("R10", 1'b0, '0);
        check("R10 unit1 idle", {v1_hi, v1_lo}, 0);
        cycles(1);
        // R10: unit 1 has its mask set, so a stall holds it even when enabled
        core_stall = 2'b01;
        do_cfg(1'b1, 2'b11);
        cycles(3);
        do_update("R10 unit1 masked", 1'b0, '0);
        check("R10 unit1 stalled", {v1_hi, v1_lo}, 0);
        core_stall = '0;
        // R2 and R1: the load puts the high word above bit 31
        do_load({20'hABCDE, 32'h1234_5678});
        do_update("R2", 1'b0, '0);
        check("R1 high word", CW'(value_hi), CW'(20'hABCDE));
        // R6: load and update in the same cycle give the loaded value
        do_update("R6", 1'b1, {20'h00042, 32'hDEAD_BEEF});
        check("R6 loaded value", {value_hi, value_lo}, {20'h00042, 32'hDEAD_BEEF});
        // R7: wrap from all ones to zero
        do_load({CW{1'b1}} - 2);
        cycles(3);
        do_update("R7 wrap", 1'b0, '0);
        check("R7 wrapped small", CW'(value_hi), 0);
        // R7: carry from the low word into the high word
        do_update("R7 carry", 1'b1, {20'h00001, 32'hFFFF_FFFF});
        do_update("R7 carry next", 1'b0, '0);
        // R8: work enable off holds the count
        do_cfg(1'b0, 2'b00);
        do_update("R8 hold a", 1'b0, '0);
        s1 = {value_hi, value_lo};
        cycles(5);
        do_update("R8 hold b", 1'b0, '0);
        check("R8 frozen", {value_hi, value_lo}, s1);
        // R9: masked stall on core 1 freezes the count
        do_cfg(1'b1, 2'b10);
        core_stall = 2'b10;
        do_update("R9 stall a", 1'b0, '0);
        s1 = {value_hi, value_lo};
        cycles(4);
        do_update("R9 stall b", 1'b0, '0);
        check("R9 masked stall frozen", {value_hi, value_lo}, s1);
        // R9: an unmasked stall on core 0 is ignored
        core_stall = 2'b01;
        do_update("R9 ignored a", 1'b0, '0);
        s1 = {value_hi, value_lo};
        cycles(2);
        do_update("R9 ignored b", 1'b0, '0);
        check("R9 unmasked stall runs", {value_hi, value_lo}, s1 + 5);
        core_stall = '0;
        cycles(3);
        check("R5 scoreboard drained", CW'(exp_q.size()), 0);
        finish_up();
    end
endmodule